// File: doc/BRIEF.md
# Battery Charge Cycle Controller

This block sequences one autonomous battery charging cycle from comparator flags that an analog front end has already digitised. It gates the start of a cycle on a set of enable and health conditions. It then steps through a low-current precharge phase and a fast-charge phase, and ends the cycle when the charge current has tapered off. From the done state it re-arms on its own when the battery sags, when the enable is toggled, or when the adapter is unplugged and plugged back in. A safety timer stops a cycle that runs too long and holds the charger in a fault state.

The outputs are a 2-bit phase code and a status pin level for an indicator LED. There is also a host interrupt pulse at the end of each cycle, and a charge command for the converter. Every input is asynchronous and passes through a two-flop synchroniser. One prescaler paces both the safety timer and the fault blink, so one parameter set scales the time base from hours down to a few hundred clocks.

The state machine has five states. `ST_IDLE` is disabled. `ST_PRE` is precharge, `ST_FAST` is fast charge, `ST_DONE` is the completed cycle, and `ST_FAULT` means the safety timer has expired. The transitions are:
- start: IDLE to PRE or FAST.
- promote: PRE to FAST.
- terminate: FAST to DONE.
- restart: DONE to PRE or FAST.
- drop: PRE, FAST or DONE to IDLE when a start condition is lost.
- expire: PRE or FAST to FAULT.
- rearm: FAULT to IDLE.

Top module: `chg_cycle_ctrl`

## Requirements
- R1: A cycle starts only when all of these hold together: the converter is running, `cfg_chg_en_i` is 1, `cfg_ichg_nz_i` is 1, `chg_en_pin_n_i` is 0, `cfg_bsw_off_i` is 0, and either `tsense_fault_i` is 0 or `cfg_tsense_ign_i` is 1. If any one of them is missing, the phase stays 00 and `chg_cmd_o` stays 0.
- R2: A starting or restarting cycle enters precharge while `bat_below_pre_i` is 1, otherwise fast charge. Precharge moves to fast charge once that flag clears.
- R3: Fast charge ends in done only when, in the same cycle, the current is below termination, the battery is above the recharge level, and neither input-limit nor thermal regulation is active.
- R4: In done, a battery falling below the recharge level starts a new cycle.
- R5: In done, a new cycle also starts on a rising edge of the adapter-present flag. A toggle of the enable pin or of the enable bit restarts charging through disabled.
- R6: `phase_o` encodes 00 disabled (including fault), 01 precharge, 10 fast charge and 11 done. `chg_cmd_o` is 1 exactly in precharge and fast charge.
- R7: `stat_pin_o` is 0 while charging and 1 when done or disabled. While a fault is present it toggles every `BLINK_TICKS` prescaler ticks. A fault is a safety timer fault, or a thermistor fault that is not ignored.
- R8: Each completed cycle raises `irq_o` once, for exactly `IRQ_LEN` clocks.
- R9: After `TIMER_TICKS` ticks of charging in one cycle the controller enters the fault state: phase 00, charge command 0. It stays there, even with every start condition true, until a rising edge of the enable or of the adapter flag.
- R10: The safety timer clears at the start of every new cycle.
- R11: Loss of any start condition during precharge, fast charge or done returns the phase to 00 and clears the charge command within the synchroniser latency plus one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_on_i | input | 1 | Converter running |
| bat_below_pre_i | input | 1 | Battery below precharge level |
| ichg_below_term_i | input | 1 | Charge current below termination level |
| vbat_above_rchg_i | input | 1 | Battery above recharge level |
| in_lim_reg_i | input | 1 | Input-limit regulation active |
| therm_reg_i | input | 1 | Thermal regulation active |
| tsense_fault_i | input | 1 | Thermistor fault |
| adapter_i | input | 1 | Adapter present |
| cfg_chg_en_i | input | 1 | Charge enable configuration bit |
| chg_en_pin_n_i | input | 1 | Active-low charge enable pin |
| cfg_ichg_nz_i | input | 1 | Charge current setting is nonzero |
| cfg_tsense_ign_i | input | 1 | Ignore thermistor |
| cfg_bsw_off_i | input | 1 | Battery switch forced off |
| phase_o | output | 2 | Charge phase code |
| stat_pin_o | output | 1 | Status pin level |
| irq_o | output | 1 | Host interrupt pulse |
| chg_cmd_o | output | 1 | Charge command to converter |

## Verification
A wrong state shows on `phase_o` and `chg_cmd_o` three clocks after the input change that caused it, because the synchronisers add two flops in front of the state register. The bench therefore samples five clocks after every stimulus. A timer that fails to clear, or that runs at the wrong rate, shows as a fault that comes too early or never comes. The bench brackets the expiry between two samples, and it restarts the cycle between them to expose a missing clear. A missing or repeated done entry shows as an interrupt pulse count other than `IRQ_LEN`. A broken fault path shows as a status pin stuck at one level over several blink periods.

// File: rtl/chg_pkg.sv
package chg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_FAST,
        ST_DONE,
        ST_FAULT
    } chg_state_e;

    localparam logic [1:0] PH_OFF  = 2'b00;
    localparam logic [1:0] PH_PRE  = 2'b01;
    localparam logic [1:0] PH_FAST = 2'b10;
    localparam logic [1:0] PH_DONE = 2'b11;

    // bit positions of the synchronised input vector
    localparam int unsigned IX_CONV    = 0;
    localparam int unsigned IX_BATLOW  = 1;
    localparam int unsigned IX_ILOW    = 2;
    localparam int unsigned IX_VABOVE  = 3;
    localparam int unsigned IX_INLIM   = 4;
    localparam int unsigned IX_THREG   = 5;
    localparam int unsigned IX_TSFLT   = 6;
    localparam int unsigned IX_ADP     = 7;
    localparam int unsigned IX_CFGEN   = 8;
    localparam int unsigned IX_PINN    = 9;
    localparam int unsigned IX_ICHGNZ  = 10;
    localparam int unsigned IX_TSIGN   = 11;
    localparam int unsigned IX_BSWOFF  = 12;
    localparam int unsigned SYN_W      = 13;

endpackage

// File: rtl/chg_sync.sv
module chg_sync #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;

endmodule

// File: rtl/chg_timebase.sv
module chg_timebase #(
    parameter int unsigned PRESCALE    = 1000000,
    parameter int unsigned BLINK_TICKS = 500
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o,
    output logic blink_o
);

    localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam int unsigned BW = (BLINK_TICKS > 1) ? $clog2(BLINK_TICKS) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);
    localparam logic [BW-1:0] BLK_LAST = BW'(BLINK_TICKS - 1);

    logic [PW-1:0] pre_q;
    logic [BW-1:0] blk_q;
    logic          blink_q;

    assign tick_o  = (pre_q == PRE_LAST);
    assign blink_o = blink_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (tick_o) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_q   <= '0;
            blink_q <= 1'b1;
        end else if (tick_o) begin
            if (blk_q == BLK_LAST) begin
                blk_q   <= '0;
                blink_q <= ~blink_q;
            end else begin
                blk_q <= blk_q + 1'b1;
            end
        end
    end

    // R7: the blink level only moves on a prescaler tick
    p_blink_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_q != $past(blink_q)) |-> $past(tick_o));

endmodule

// File: rtl/chg_safety_timer.sv
module chg_safety_timer #(
    parameter int unsigned TIMER_TICKS = 36000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic run_i,
    input  logic clr_i,
    output logic expired_o
);

    localparam int unsigned TW = $clog2(TIMER_TICKS + 1);
    localparam logic [TW-1:0] T_LIMIT = TW'(TIMER_TICKS);

    logic [TW-1:0] cnt_q;

    assign expired_o = (cnt_q == T_LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (run_i && tick_i && !expired_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R9: the count never passes the limit
    p_timer_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= T_LIMIT);

    // R10: an expiry stays until a clear
    p_expiry_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && !clr_i) |=> expired_o);

endmodule

// File: rtl/chg_cycle_ctrl.sv
module chg_cycle_ctrl
    import chg_pkg::*;
#(
    parameter int unsigned PRESCALE    = 1000000,
    parameter int unsigned TIMER_TICKS = 36000000,
    parameter int unsigned BLINK_TICKS = 500,
    parameter int unsigned IRQ_LEN     = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       conv_on_i,
    input  logic       bat_below_pre_i,
    input  logic       ichg_below_term_i,
    input  logic       vbat_above_rchg_i,
    input  logic       in_lim_reg_i,
    input  logic       therm_reg_i,
    input  logic       tsense_fault_i,
    input  logic       adapter_i,
    input  logic       cfg_chg_en_i,
    input  logic       chg_en_pin_n_i,
    input  logic       cfg_ichg_nz_i,
    input  logic       cfg_tsense_ign_i,
    input  logic       cfg_bsw_off_i,
    output logic [1:0] phase_o,
    output logic       stat_pin_o,
    output logic       irq_o,
    output logic       chg_cmd_o
);

    localparam int unsigned IW = $clog2(IRQ_LEN + 1);
    localparam logic [IW-1:0] IRQ_LOAD = IW'(IRQ_LEN);

    logic [SYN_W-1:0] raw_in;
    logic [SYN_W-1:0] syn;

    assign raw_in[IX_CONV]   = conv_on_i;
    assign raw_in[IX_BATLOW] = bat_below_pre_i;
    assign raw_in[IX_ILOW]   = ichg_below_term_i;
    assign raw_in[IX_VABOVE] = vbat_above_rchg_i;
    assign raw_in[IX_INLIM]  = in_lim_reg_i;
    assign raw_in[IX_THREG]  = therm_reg_i;
    assign raw_in[IX_TSFLT]  = tsense_fault_i;
    assign raw_in[IX_ADP]    = adapter_i;
    assign raw_in[IX_CFGEN]  = cfg_chg_en_i;
    assign raw_in[IX_PINN]   = chg_en_pin_n_i;
    assign raw_in[IX_ICHGNZ] = cfg_ichg_nz_i;
    assign raw_in[IX_TSIGN]  = cfg_tsense_ign_i;
    assign raw_in[IX_BSWOFF] = cfg_bsw_off_i;

    chg_sync #(.W(SYN_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (syn)
    );

    logic tick;
    logic blink;

    chg_timebase #(
        .PRESCALE    (PRESCALE),
        .BLINK_TICKS (BLINK_TICKS)
    ) u_timebase (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_o  (tick),
        .blink_o (blink)
    );

    chg_state_e state_q, state_d;
    logic       charging_q, charging_d;
    logic       tmr_clr, tmr_exp;

    assign charging_q = (state_q == ST_PRE) || (state_q == ST_FAST);
    assign charging_d = (state_d == ST_PRE) || (state_d == ST_FAST);
    assign tmr_clr    = charging_d && !charging_q;

    chg_safety_timer #(.TIMER_TICKS(TIMER_TICKS)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .run_i     (charging_q),
        .clr_i     (tmr_clr),
        .expired_o (tmr_exp)
    );

    // qualified conditions
    logic ts_bad, en_now, start_ok, term_ok;
    logic en_q, adp_q, en_rise, adp_rise;

    assign ts_bad   = syn[IX_TSFLT] && !syn[IX_TSIGN];
    assign en_now   = syn[IX_CFGEN] && !syn[IX_PINN];
    assign start_ok = syn[IX_CONV] && en_now && syn[IX_ICHGNZ]
                   && !ts_bad && !syn[IX_BSWOFF];
    assign term_ok  = syn[IX_ILOW] && syn[IX_VABOVE]
                   && !syn[IX_INLIM] && !syn[IX_THREG];
    assign en_rise  = en_now && !en_q;
    assign adp_rise = syn[IX_ADP] && !adp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            adp_q <= 1'b0;
        end else begin
            en_q  <= en_now;
            adp_q <= syn[IX_ADP];
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_ok) state_d = syn[IX_BATLOW] ? ST_PRE : ST_FAST;
            end
            ST_PRE: begin
                if (!start_ok)          state_d = ST_IDLE;
                else if (tmr_exp)       state_d = ST_FAULT;
                else if (!syn[IX_BATLOW]) state_d = ST_FAST;
            end
            ST_FAST: begin
                if (!start_ok)    state_d = ST_IDLE;
                else if (tmr_exp) state_d = ST_FAULT;
                else if (term_ok) state_d = ST_DONE;
            end
            ST_DONE: begin
                if (!start_ok) state_d = ST_IDLE;
                else if (!syn[IX_VABOVE] || adp_rise)
                    state_d = syn[IX_BATLOW] ? ST_PRE : ST_FAST;
            end
            ST_FAULT: begin
                if (en_rise || adp_rise) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // interrupt pulse stretcher
    logic [IW-1:0] irq_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_cnt_q <= '0;
        end else if (state_q == ST_FAST && state_d == ST_DONE) begin
            irq_cnt_q <= IRQ_LOAD;
        end else if (irq_cnt_q != '0) begin
            irq_cnt_q <= irq_cnt_q - 1'b1;
        end
    end

    assign irq_o = (irq_cnt_q != '0);

    // outputs from state
    always_comb begin
        phase_o   = PH_OFF;
        chg_cmd_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  phase_o = PH_OFF;
            ST_PRE:   begin phase_o = PH_PRE;  chg_cmd_o = 1'b1; end
            ST_FAST:  begin phase_o = PH_FAST; chg_cmd_o = 1'b1; end
            ST_DONE:  phase_o = PH_DONE;
            ST_FAULT: phase_o = PH_OFF;
            default:  phase_o = PH_OFF;
        endcase
        if ((state_q == ST_FAULT) || ts_bad) stat_pin_o = blink;
        else                                 stat_pin_o = !chg_cmd_o;
    end

    // R1: charging is only ever held with all start conditions met
    p_cmd_needs_ok_r1: assert property (@(posedge clk) disable iff (!rst_n)
        chg_cmd_o |-> $past(start_ok));

    // R3: done is entered only from fast charge
    p_done_from_fast_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_DONE && $past(phase_o) != PH_DONE) |-> $past(phase_o) == PH_FAST);

    // R3: no termination under regulation
    p_term_unregulated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_DONE && $past(phase_o) == PH_FAST)
            |-> ($past(!syn[IX_INLIM]) && $past(!syn[IX_THREG])));

    // R8: the interrupt starts together with done
    p_irq_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> phase_o == PH_DONE);

    // R9: the fault state can only be left for disabled
    p_fault_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAULT) |=> (state_q == ST_FAULT || state_q == ST_IDLE));

endmodule

// File: tb/chg_cycle_ctrl_bench.sv
module chg_cycle_ctrl_bench;

    localparam int unsigned PRESCALE    = 4;
    localparam int unsigned TIMER_TICKS = 60;
    localparam int unsigned BLINK_TICKS = 2;
    localparam int unsigned IRQ_LEN     = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv_on, bat_low, ilow, vabove, inlim, threg, tsflt, adp;
    logic cfg_en, pin_n, ichg_nz, ts_ign, bsw_off;
    logic [1:0] phase;
    logic stat, irq, cmd;

    int n_vec = 0;
    int n_bad = 0;
    int irq_hits = 0;

    always #2 clk = ~clk;

    chg_cycle_ctrl #(
        .PRESCALE    (PRESCALE),
        .TIMER_TICKS (TIMER_TICKS),
        .BLINK_TICKS (BLINK_TICKS),
        .IRQ_LEN     (IRQ_LEN)
    ) u_chg_cycle_ctrl (
        .clk               (clk),
        .rst_n             (rst_n),
        .conv_on_i         (conv_on),
        .bat_below_pre_i   (bat_low),
        .ichg_below_term_i (ilow),
        .vbat_above_rchg_i (vabove),
        .in_lim_reg_i      (inlim),
        .therm_reg_i       (threg),
        .tsense_fault_i    (tsflt),
        .adapter_i         (adp),
        .cfg_chg_en_i      (cfg_en),
        .chg_en_pin_n_i    (pin_n),
        .cfg_ichg_nz_i     (ichg_nz),
        .cfg_tsense_ign_i  (ts_ign),
        .cfg_bsw_off_i     (bsw_off),
        .phase_o           (phase),
        .stat_pin_o        (stat),
        .irq_o             (irq),
        .chg_cmd_o         (cmd)
    );

    always @(negedge clk) if (rst_n && irq) irq_hits++;

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (5) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_state(input string req, input int ph, input int c);
        check({req, " phase"}, phase, ph);
        check({req, " cmd"}, cmd, c);
    endtask

    // status pin must take both levels over several blink periods
    task automatic check_blink(input string req);
        int ones = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (stat) ones++;
        end
        check({req, " blink has highs"}, (ones > 0) ? 1 : 0, 1);
        check({req, " blink has lows"}, (ones < 40) ? 1 : 0, 1);
    endtask

    task automatic t_reset();
        conv_on = 1; bat_low = 1; ilow = 0; vabove = 0; inlim = 0; threg = 0;
        tsflt = 0; adp = 1; cfg_en = 0; pin_n = 0; ichg_nz = 1; ts_ign = 0; bsw_off = 0;
        rst_n = 0;
        wait_clk(4);
        check_state("R6 reset", 0, 0);
        check("R8 reset irq", irq, 0);
        check("R7 reset stat", stat, 1);
        rst_n = 1;
        settle();
        check_state("R1 cfg bit off", 0, 0);
    endtask

    task automatic set_cond(input int k, input logic bad);
        case (k)
            0: conv_on = !bad;
            1: cfg_en  = !bad;
            2: pin_n   = bad;
            3: ichg_nz = !bad;
            4: tsflt   = bad;
            default: bsw_off = bad;
        endcase
    endtask

    task automatic t_start_gate();
        cfg_en = 1;
        settle();
        check_state("R1 all met", 1, 1);
        for (int k = 0; k < 6; k++) begin
            set_cond(k, 1'b1);
            settle();
            check_state("R1 one missing", 0, 0);
            set_cond(k, 1'b0);
            settle();
            check_state("R1 restored", 1, 1);
        end
        tsflt = 1; ts_ign = 1;
        settle();
        check_state("R1 thermistor ignored", 1, 1);
        check("R7 charging stat low", stat, 0);
        tsflt = 0; ts_ign = 0;
        settle();
    endtask

    task automatic t_phase();
        check_state("R2 precharge", 1, 1);
        bat_low = 0;
        settle();
        check_state("R2 promote to fast", 2, 1);
        check("R7 fast stat low", stat, 0);
    endtask

    task automatic t_terminate();
        ilow = 1;
        settle();
        check_state("R3 battery not above recharge", 2, 1);
        vabove = 1; inlim = 1;
        settle();
        check_state("R3 input limit blocks", 2, 1);
        inlim = 0; threg = 1;
        settle();
        check_state("R3 thermal blocks", 2, 1);
        irq_hits = 0;
        threg = 0;
        settle();
        check_state("R3 terminated", 3, 0);
        check("R7 done stat high", stat, 1);
        wait_clk(20);
        check("R8 irq length", irq_hits, IRQ_LEN);
        check_state("R3 done holds", 3, 0);
    endtask

    task automatic t_recharge();
        vabove = 0;
        settle();
        check_state("R4 recharge restart", 2, 1);
        irq_hits = 0;
        vabove = 1;
        settle();
        check_state("R4 second termination", 3, 0);
        wait_clk(10);
        check("R8 second irq length", irq_hits, IRQ_LEN);
    endtask

    task automatic t_rearm();
        ilow = 0;
        adp = 0;
        settle();
        check_state("R5 adapter removed stays done", 3, 0);
        adp = 1;
        settle();
        check_state("R5 adapter replug restart", 2, 1);
        ilow = 1; settle(); ilow = 0;
        check_state("R5 done before pin toggle", 3, 0);
        pin_n = 1;
        settle();
        check_state("R5 pin off", 0, 0);
        pin_n = 0;
        settle();
        check_state("R5 pin toggle restart", 2, 1);
        ilow = 1; settle(); ilow = 0;
        cfg_en = 0;
        settle();
        check_state("R5 bit off", 0, 0);
        cfg_en = 1;
        settle();
        check_state("R5 bit toggle restart", 2, 1);
    endtask

    task automatic t_timer();
        pin_n = 1; settle(); pin_n = 0; settle();
        wait_clk(150);
        check_state("R10 first half", 2, 1);
        pin_n = 1; settle(); pin_n = 0; settle();
        wait_clk(150);
        check_state("R10 timer cleared by restart", 2, 1);
        wait_clk(150);
        check_state("R9 timer expired", 0, 0);
        check_blink("R9 R7 timer fault");
        wait_clk(30);
        check_state("R9 fault holds", 0, 0);
        adp = 0; settle(); adp = 1;
        settle();
        check_state("R9 replug clears fault", 2, 1);
    endtask

    task automatic t_fault_drop();
        tsflt = 1;
        wait_clk(3);
        check_state("R11 thermistor drop", 0, 0);
        check_blink("R7 thermistor fault");
        ts_ign = 1;
        settle();
        check_state("R11 ignore resumes", 2, 1);
        check("R7 stat low again", stat, 0);
        bsw_off = 1;
        wait_clk(3);
        check_state("R11 switch forced off", 0, 0);
        check("R7 disabled stat high", stat, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_start_gate();
        t_phase();
        t_terminate();
        t_recharge();
        t_rearm();
        t_timer();
        t_fault_drop();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule